// File: doc/BRIEF.md
# Cluster Barrier Synchronizer

This block lets up to four cores of one cluster meet at a hardware barrier without polling a shared variable. Each core presents a request that names a barrier. The unit routes it to the barrier instance with that number and records the core as arrived. It then holds the core stalled through a per-core pause output. When every core listed in that barrier's participant set has arrived, all of them are released together and the barrier is ready for its next round.

Each barrier instance has its own participant mask and a flag that makes it hierarchical. A hierarchical barrier does not release on local completion. It raises an upward request to a higher-level synchronizer and releases only when that level answers on a release input. A request that is malformed leaves all state unchanged and raises a one-cycle exception to the core that issued it.

Top module: `cluster_barrier_unit`

## Requirements
- R1: After reset, `pause`, `exc` and `up_req` are all zero.
- R2: An accepted request from core c sets `pause[c]` at the clock edge that samples the request. The bit stays set until the barrier releases.
- R3: In the cycle after the last participant's arrival is registered, the barrier completes. A non-hierarchical barrier drops the pause bits of all its participants at the next edge and clears its arrivals, so a new round can start at once.
- R4: A request for a barrier whose mask (core c is bit c of slice `cfg_mask[b*4 +: 4]`) excludes the requesting core raises `exc[c]` for exactly one cycle, starting one edge after the request. The request changes no state.
- R5: A second request from a core that has already arrived at the same barrier raises `exc` and changes no state.
- R6: A barrier number of 4 or more (with 3-bit numbers `req_bar[c*3 +: 3]`) raises `exc` and changes no state.
- R7: A request to a barrier whose mask has fewer than two bits set raises `exc` and changes no state.
- R8: A stalled core that requests a different barrier raises `exc`, stays stalled, and is not recorded at the other barrier.
- R9: When `cfg_hier[b]` is 1, completion raises `up_req[b]` one edge later and the participants stay stalled. When `up_release[b]` is sampled high while `up_req[b]` is set, the next edge releases them and clears `up_req[b]`.
- R10: Barriers with disjoint participant sets progress and release independently.
- R11: Several cores that arrive at one barrier in the same cycle are all recorded.
- R12: `up_release[b]` has no effect while `up_req[b]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 4 | Per-core barrier request strobe |
| req_bar | input | 12 | Per-core barrier number, 3 bits per core |
| cfg_mask | input | 16 | Participant mask, 4 bits per barrier |
| cfg_hier | input | 4 | Per-barrier hierarchical flag |
| up_release | input | 4 | Release from the upper level, one bit per barrier |
| pause | output | 4 | Per-core stall |
| exc | output | 4 | Per-core one-cycle exception pulse |
| up_req | output | 4 | Per-barrier upward completion request |

## Verification
The bench uses the default build: four cores, four barriers and 3-bit barrier numbers. Numbers 4 to 7 therefore reach the out-of-range path. The masks are set so that two barriers have disjoint pairs of cores, one three-core barrier is hierarchical, and one barrier has only a single bit set. With this setup the bench can drive the invalid-mask case, independent progress of two barriers, and the upward handshake. It can also check that a rejected cross-barrier request leaves no trace, because the hierarchical barrier then fails to complete early.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

    localparam int MIN_PARTICIPANTS = 2;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_RANGE     = 3'd1,
        CAUSE_BAD_MASK  = 3'd2,
        CAUSE_NONMEMBER = 3'd3,
        CAUSE_REPEAT    = 3'd4,
        CAUSE_BUSY      = 3'd5
    } cause_e;

endpackage

// File: rtl/cbar_req_check.sv
module cbar_req_check
    import cbar_pkg::*;
#(
    parameter int NC       = 4,
    parameter int NB       = 4,
    parameter int BW       = 3,
    parameter int CORE_IDX = 0
) (
    input  logic             req_valid,
    input  logic [BW-1:0]    req_bar,
    input  logic [NB*NC-1:0] cfg_mask,
    input  logic [NB*NC-1:0] arrived_all,
    input  logic             paused,
    output logic             accept,
    output logic             exc,
    output logic [NB-1:0]    join_sel
);

    cause_e        cause;
    logic [BW-1:0] bidx;
    logic [NC-1:0] mask;
    logic [NC-1:0] arr;
    logic          in_range;

    always_comb begin
        in_range = (32'(req_bar) < NB);
        bidx     = in_range ? req_bar : '0;
        mask     = cfg_mask[bidx*NC +: NC];
        arr      = arrived_all[bidx*NC +: NC];
        cause    = CAUSE_NONE;
        if (req_valid) begin
            if (!in_range)
                cause = CAUSE_RANGE;
            else if ($countones(mask) < MIN_PARTICIPANTS)
                cause = CAUSE_BAD_MASK;
            else if (!mask[CORE_IDX])
                cause = CAUSE_NONMEMBER;
            else if (arr[CORE_IDX])
                cause = CAUSE_REPEAT;
            else if (paused)
                cause = CAUSE_BUSY;
        end
        accept = req_valid && (cause == CAUSE_NONE);
        exc    = req_valid && (cause != CAUSE_NONE);
        for (int b = 0; b < NB; b++)
            join_sel[b] = accept && (bidx == BW'(b));
    end

endmodule

// File: rtl/cbar_instance.sv
module cbar_instance
    import cbar_pkg::*;
#(
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] mask,
    input  logic          hier,
    input  logic [NC-1:0] join_vec,
    input  logic          up_release,
    output logic [NC-1:0] arrived,
    output logic          up_req,
    output logic          release_o
);

    typedef struct packed {
        logic [NC-1:0] arrived;
        logic          up_wait;
    } inst_st_t;

    inst_st_t st_d, st_q;
    logic     complete;
    logic     rel;

    always_comb begin
        st_d     = st_q;
        rel      = 1'b0;
        complete = ($countones(mask) >= MIN_PARTICIPANTS) && !st_q.up_wait
                   && (st_q.arrived == mask);
        if (st_q.up_wait) begin
            if (up_release) begin
                rel  = 1'b1;
                st_d = '0;
            end
        end else if (complete) begin
            if (hier) begin
                st_d.up_wait = 1'b1;
            end else begin
                rel          = 1'b1;
                st_d.arrived = '0;
            end
        end else begin
            st_d.arrived = st_q.arrived | join_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign arrived   = st_q.arrived;
    assign up_req    = st_q.up_wait;
    assign release_o = rel;

endmodule

// File: rtl/cluster_barrier_unit.sv
module cluster_barrier_unit
    import cbar_pkg::*;
#(
    parameter int NUM_CORES    = 4,
    parameter int NUM_BARRIERS = 4,
    parameter int BAR_ID_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CORES-1:0]            req_valid,
    input  logic [NUM_CORES*BAR_ID_W-1:0]   req_bar,
    input  logic [NUM_BARRIERS*NUM_CORES-1:0] cfg_mask,
    input  logic [NUM_BARRIERS-1:0]         cfg_hier,
    input  logic [NUM_BARRIERS-1:0]         up_release,
    output logic [NUM_CORES-1:0]            pause,
    output logic [NUM_CORES-1:0]            exc,
    output logic [NUM_BARRIERS-1:0]         up_req
);

    localparam int NC = NUM_CORES;
    localparam int NB = NUM_BARRIERS;

    typedef struct packed {
        logic [NC-1:0] pause;
        logic [NC-1:0] exc;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NC-1:0]          accept;
    logic [NC-1:0]          exc_raw;
    logic [NC-1:0][NB-1:0]  sel_by_core;
    logic [NB-1:0][NC-1:0]  join_by_bar;
    logic [NB*NC-1:0]       arrived_all;
    logic [NB-1:0]          bar_release;
    logic [NC-1:0]          freed;

    for (genvar c = 0; c < NC; c++) begin : g_core
        cbar_req_check #(
            .NC(NC), .NB(NB), .BW(BAR_ID_W), .CORE_IDX(c)
        ) u_check (
            .req_valid   (req_valid[c]),
            .req_bar     (req_bar[c*BAR_ID_W +: BAR_ID_W]),
            .cfg_mask    (cfg_mask),
            .arrived_all (arrived_all),
            .paused      (st_q.pause[c]),
            .accept      (accept[c]),
            .exc         (exc_raw[c]),
            .join_sel    (sel_by_core[c])
        );
    end

    for (genvar b = 0; b < NB; b++) begin : g_bar
        for (genvar c = 0; c < NC; c++) begin : g_tr
            assign join_by_bar[b][c] = sel_by_core[c][b];
        end
        cbar_instance #(.NC(NC)) u_inst (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask       (cfg_mask[b*NC +: NC]),
            .hier       (cfg_hier[b]),
            .join_vec   (join_by_bar[b]),
            .up_release (up_release[b]),
            .arrived    (arrived_all[b*NC +: NC]),
            .up_req     (up_req[b]),
            .release_o  (bar_release[b])
        );
    end

    always_comb begin
        freed = '0;
        for (int b = 0; b < NB; b++)
            if (bar_release[b]) freed = freed | arrived_all[b*NC +: NC];
        st_d.pause = (st_q.pause | accept) & ~freed;
        st_d.exc   = exc_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pause = st_q.pause;
    assign exc   = st_q.exc;

endmodule

// File: rtl/cbar_checker.sv
module cbar_checker #(
    parameter int NC = 4,
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NC-1:0] req_valid,
    input logic [NB-1:0] up_release,
    input logic [NC-1:0] pause,
    input logic [NC-1:0] exc,
    input logic [NB-1:0] up_req
);

    // R4
    exc_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc & ~$past(req_valid)) == '0);

    // R2
    pause_rise_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pause & ~$past(pause)) & ~$past(req_valid)) == '0);

    // R8
    exc_not_with_new_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc & pause & ~$past(pause)) == '0);

    // R9
    up_req_drop_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_req) & ~up_req & ~$past(up_release)) == '0);

    // R12
    up_req_stays_while_no_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(up_req) & ~$past(up_release))) |-> (($past(up_req) & ~$past(up_release) & ~up_req) == '0));

endmodule

bind cluster_barrier_unit cbar_checker #(.NC(NUM_CORES), .NB(NUM_BARRIERS)) u_cbar_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .up_release (up_release),
    .pause      (pause),
    .exc        (exc),
    .up_req     (up_req)
);

// File: tb/cluster_barrier_unit_test.sv
module cluster_barrier_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_valid = '0;
    logic [11:0] req_bar = '0;
    logic [15:0] cfg_mask;
    logic [3:0]  cfg_hier;
    logic [3:0]  up_release = '0;
    logic [3:0]  pause;
    logic [3:0]  exc;
    logic [3:0]  up_req;

    int total = 0;
    int bad = 0;

    // barrier0: cores 0,1; barrier1: cores 2,3; barrier2: cores 0,1,2 hierarchical;
    // barrier3: core 0 only (invalid)
    assign cfg_mask = {4'b0001, 4'b0111, 4'b1100, 4'b0011};
    assign cfg_hier = 4'b0100;

    always #5 clk = ~clk;

    cluster_barrier_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bar(req_bar),
        .cfg_mask(cfg_mask), .cfg_hier(cfg_hier), .up_release(up_release),
        .pause(pause), .exc(exc), .up_req(up_req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic put(input int core, input int bar);
        req_valid[core] = 1'b1;
        req_bar[core*3 +: 3] = 3'(bar);
    endtask

    task automatic clr();
        req_valid = '0;
        up_release = '0;
    endtask

    task automatic t_reset();
        chk("R1 pause", pause, 4'b0000);
        chk("R1 exc", exc, 4'b0000);
        chk("R1 up_req", up_req, 4'b0000);
    endtask

    task automatic t_basic();
        put(0, 0); step(); clr();
        chk("R2 first arrival stalls", pause, 4'b0001);
        put(1, 0); step(); clr();
        chk("R3 last arrival stalls one cycle", pause, 4'b0011);
        step();
        chk("R3 release", pause, 4'b0000);
        put(0, 0); step(); clr();
        chk("R3 new round accepted", pause, 4'b0001);
        put(1, 0); step(); clr(); step();
        chk("R3 second round release", pause, 4'b0000);
    endtask

    task automatic t_simul();
        put(2, 1); put(3, 1); step(); clr();
        chk("R11 both recorded", pause, 4'b1100);
        step();
        chk("R11 released together", pause, 4'b0000);
    endtask

    task automatic t_nonmember();
        put(2, 0); step(); clr();
        chk("R4 exc", exc, 4'b0100);
        chk("R4 no stall", pause, 4'b0000);
        step();
        chk("R4 exc one cycle", exc, 4'b0000);
    endtask

    task automatic t_repeat();
        put(0, 0); step(); clr();
        put(0, 0); step(); clr();
        chk("R5 exc", exc, 4'b0001);
        chk("R5 still stalled", pause, 4'b0001);
        put(1, 0); step(); clr(); step();
        chk("R5 barrier completes normally", pause, 4'b0000);
    endtask

    task automatic t_range();
        put(0, 5); put(1, 7); step(); clr();
        chk("R6 exc", exc, 4'b0011);
        chk("R6 no stall", pause, 4'b0000);
    endtask

    task automatic t_badmask();
        put(0, 3); step(); clr();
        chk("R7 exc", exc, 4'b0001);
        chk("R7 no stall", pause, 4'b0000);
    endtask

    task automatic t_cross_and_hier();
        up_release = 4'b0100; step(); clr();
        chk("R12 release ignored up_req", up_req, 4'b0000);
        chk("R12 release ignored pause", pause, 4'b0000);
        put(0, 0); step(); clr();
        put(0, 2); step(); clr();
        chk("R8 exc", exc, 4'b0001);
        chk("R8 still stalled", pause, 4'b0001);
        put(1, 0); step(); clr(); step();
        chk("R8 original barrier released", pause, 4'b0000);
        put(1, 2); put(2, 2); step(); clr(); step(); step();
        chk("R8 core0 not recorded at barrier2", up_req, 4'b0000);
        chk("R9 partial stall", pause, 4'b0110);
        put(0, 2); step(); clr();
        chk("R9 all stalled", pause, 4'b0111);
        chk("R9 up_req not yet", up_req, 4'b0000);
        step();
        chk("R9 up_req raised", up_req, 4'b0100);
        step(); step();
        chk("R9 held while waiting", pause, 4'b0111);
        up_release = 4'b0100; step(); clr();
        chk("R9 released", pause, 4'b0000);
        chk("R9 up_req cleared", up_req, 4'b0000);
    endtask

    task automatic t_indep();
        put(0, 0); put(2, 1); step(); clr();
        chk("R10 two barriers", pause, 4'b0101);
        put(1, 0); step(); clr();
        chk("R10 barrier0 full", pause, 4'b0111);
        step();
        chk("R10 only barrier0 released", pause, 4'b0100);
        put(3, 1); step(); clr(); step();
        chk("R10 barrier1 released", pause, 4'b0000);
    endtask

    initial begin
        fork
            begin
                step(); step();
                rst_n = 1'b1;
                step();
                t_reset();
                t_basic();
                t_simul();
                t_nonmember();
                t_repeat();
                t_range();
                t_badmask();
                t_cross_and_hier();
                t_indep();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule